// File: doc/BRIEF.md
# Network Controller Command and Interrupt Register

This block holds the 16-bit command and status word of a descriptor-ring network controller and gathers its interrupt causes into one active-low interrupt line. The host writes the word through a plain single-register bus: a write with valid data issues the stop, start and init commands, programs the interrupt enable, acknowledges cause bits and requests a transmit poll. A read returns the live status at once.

Event pulses arrive from the DMA engine: a transmit frame finished (with a success flag), and the init block has been loaded. A separate mask register supplies the mask bits for the two local causes. The other cause sources arrive as pre-gated levels. The system and sleep sources arrive as one level that asserts the interrupt even when the global enable is off. The block sequences start, init and stop, drives the receive-on and transmit-on status, and runs the transmit-demand handshake with the buffer manager.

Bit map of `rd_data` / `wr_data`:

| Bit | Meaning |
|---|---|
| 9 | transmit-done cause |
| 8 | init-done cause |
| 7 | summary flag |
| 6 | interrupt enable |
| 5 | receive-on |
| 4 | transmit-on |
| 3 | transmit demand |
| 2 | stop |
| 1 | start accepted |
| 0 | init in progress |

Bits 15 to 10 read 0.

Top module: `netctl_csr`

## Requirements
- R1: While `rst_n` is low, and on the first read after it, `rd_data` is 16'h0004 (only the stop bit, bit 2, is set), `irq_n` is 1, and `poll_req` and `init_busy` are 0. Bits 15:10 always read 0.
- R2: One cycle after a pulse on `ev_tx_done` while stop (bit 2) is 0, bit 9 reads 1. The exception is when `cfg_tx_quiet` and `ev_tx_ok` are both 1, in which case bit 9 is not set. A pulse while stop is 1 leaves bit 9 at 0.
- R3: Writing 1 to bit 9 or bit 8 clears that bit on the next cycle, and writing 0 leaves it unchanged. If a set event and a write-1 clear of the same bit occur in the same cycle, the bit reads 1 afterwards.
- R4: Bit 7 is read-only. It equals the OR of (bit 9 and not `int_mask[9]`), (bit 8 and not `int_mask[8]`), any bit of `ext_cause`, and `sys_cause`, and it follows these inputs in the same cycle.
- R5: `irq_n` is registered. It is 0 in the cycle after one in which (bit 6 and bit 7) or `sys_cause` held, and 1 otherwise.
- R6: Every write that does not set stop loads bit 6 from `wr_data[6]`.
- R7: A write with `wr_data[1]`=1, with `wr_data[0]`=0 and `wr_data[2]`=0, while no init is in progress, does four things on the next cycle. It clears stop, sets bit 1, sets bit 5 to the inverse of `cfg_rx_dis`, and sets bit 4 to the inverse of `cfg_tx_dis`.
- R8: A write with `wr_data[0]`=1 (and `wr_data[2]`=0) clears stop and sets bit 0 and `init_busy`. If start is written with it, or while init is in progress, bits 5 and 4 keep their values until `ev_init_done` arrives. One cycle after that event, bits 0 and `init_busy` are 0, bit 8 is 1, and bits 5 and 4 follow the disable inputs.
- R9: Writing 1 to bit 3 while bit 4 is 1 sets bit 3 and `poll_req` on the next cycle. They stay set until `poll_ack`, after which they read 0, unless a new write-1 arrives in the same cycle as the acknowledge. If bit 4 is 0, the write leaves bit 3 at 0.
- R10: A write with `wr_data[2]`=1 wins over start and init in the same write. On the next cycle bit 2 is 1 and bits 9, 8, 6, 5, 4, 3, 1 and 0 are 0. A `soft_rst` pulse has the same effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| soft_rst | input | 1 | Synchronous soft reset pulse, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data |
| int_mask | input | 16 | Mask register; bits 9 and 8 mask the local causes |
| cfg_tx_quiet | input | 1 | Suppress transmit-done on successful frames |
| cfg_rx_dis | input | 1 | Receive disable |
| cfg_tx_dis | input | 1 | Transmit disable |
| ev_tx_done | input | 1 | Pulse: last descriptor of a transmit frame returned |
| ev_tx_ok | input | 1 | Qualifies `ev_tx_done`: frame sent without error |
| ev_init_done | input | 1 | Pulse: init block read complete |
| ext_cause | input | N_EXT | Other unmasked interrupt causes, levels |
| sys_cause | input | 1 | System/sleep interrupt level, bypasses the enable |
| init_busy | output | 1 | Request to the DMA engine to fetch the init block |
| poll_req | output | 1 | Transmit descriptor poll request |
| poll_ack | input | 1 | Buffer manager has polled a descriptor |
| irq_n | output | 1 | Interrupt output, active low |

## Verification
A wrong internal state in this block shows up on `rd_data` no later than the cycle after it forms. Every state bit is read back directly, and the summary flag and interrupt line are derived from those bits within a cycle. A lost start-pending flag stays hidden until `ev_init_done`. At that point receive-on and transmit-on fail to rise, so the scenario deliberately lets several idle cycles pass before the event. Errors in the transmit-demand handshake show on `poll_req` in the cycle after the write or the acknowledge.

// File: rtl/netctl_pkg.sv
// Shared bit positions and the decoded command type for the command/interrupt
// register. Bit positions are fixed because software and neighbours decode them.
package netctl_pkg;
    localparam int CSR_W     = 16;
    localparam int B_TXINT   = 9;
    localparam int B_IDON    = 8;
    localparam int B_SUM     = 7;
    localparam int B_IEN     = 6;
    localparam int B_RXON    = 5;
    localparam int B_TXON    = 4;
    localparam int B_TDMD    = 3;
    localparam int B_STOP    = 2;
    localparam int B_START   = 1;
    localparam int B_INIT    = 0;

    typedef struct packed {
        logic stop;
        logic start;
        logic init;
    } cmd_t;
endpackage

// File: rtl/netctl_cmd_seq.sv
// Command sequencer: tracks stop, start-accepted, init-in-progress, a pending
// start waiting on init, and the receive/transmit enables.
// Assumes cmd.start and cmd.init are already suppressed when cmd.stop is set.
module netctl_cmd_seq
    import netctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  cmd_t cmd,
    input  logic init_done_ev,
    input  logic cfg_rx_dis,
    input  logic cfg_tx_dis,
    output logic stop,
    output logic started,
    output logic start_pend,
    output logic init_busy,
    output logic rxon,
    output logic txon,
    output logic init_fin,
    output logic flush
);
    logic go;
    logic pend_set;

    // Decode the cycle's control events.
    always_comb begin
        flush    = soft_rst | cmd.stop;
        init_fin = init_busy & init_done_ev & ~cmd.init;
        pend_set = cmd.start & (cmd.init | (init_busy & ~init_done_ev));
        go       = (cmd.start & ~pend_set) | (init_fin & start_pend);
    end

    // Sequencer state update; stop and resets dominate everything.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            stop       <= 1'b1;
            started    <= 1'b0;
            start_pend <= 1'b0;
            init_busy  <= 1'b0;
            rxon       <= 1'b0;
            txon       <= 1'b0;
        end else begin
            if (cmd.start || cmd.init) stop <= 1'b0;
            if (cmd.init)      init_busy <= 1'b1;
            else if (init_fin) init_busy <= 1'b0;
            if (pend_set)      start_pend <= 1'b1;
            else if (init_fin) start_pend <= 1'b0;
            if (go) begin
                started <= 1'b1;
                rxon    <= ~cfg_rx_dis;
                txon    <= ~cfg_tx_dis;
            end
        end
    end
endmodule

// File: rtl/netctl_int_agg.sv
// Interrupt aggregation: write-one-to-clear cause bits, global enable,
// combinational summary flag and the registered active-low interrupt line.
// Assumes flush carries soft reset and stop; the line itself resets only on rst_n.
module netctl_int_agg
    import netctl_pkg::*;
#(
    parameter int N_EXT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    input  logic             ev_tx_done,
    input  logic             ev_tx_ok,
    input  logic             cfg_tx_quiet,
    input  logic             init_fin,
    input  logic             stop,
    input  logic [CSR_W-1:0] int_mask,
    input  logic [N_EXT-1:0] ext_cause,
    input  logic             sys_cause,
    output logic             txint,
    output logic             idon,
    output logic             ien,
    output logic             summary,
    output logic             irq_n
);
    logic txint_set, txint_clr, idon_clr;

    // Set and clear terms for the two local causes.
    always_comb begin
        txint_set = ev_tx_done & ~stop & ~(cfg_tx_quiet & ev_tx_ok);
        txint_clr = wr_en & wr_data[B_TXINT];
        idon_clr  = wr_en & wr_data[B_IDON];
        summary   = (txint & ~int_mask[B_TXINT]) | (idon & ~int_mask[B_IDON])
                  | (|ext_cause) | sys_cause;
    end

    // Cause and enable bits; a hardware set beats a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            txint <= 1'b0;
            idon  <= 1'b0;
            ien   <= 1'b0;
        end else begin
            txint <= txint_set | (txint & ~txint_clr);
            idon  <= init_fin  | (idon  & ~idon_clr);
            if (wr_en) ien <= wr_data[B_IEN];
        end
    end

    // Interrupt line: gated by the enable, except for the bypass source.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_n <= 1'b1;
        else        irq_n <= ~((ien & summary) | sys_cause);
    end
endmodule

// File: rtl/netctl_tx_demand.sv
// Transmit-demand handshake: the host requests a poll, the buffer manager
// acknowledges it. A request without the transmitter on is dropped.
module netctl_tx_demand (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic set_req,
    input  logic txon,
    input  logic poll_ack,
    output logic tdmd
);
    // Demand flag; a new request in the acknowledge cycle keeps it set.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) tdmd <= 1'b0;
        else                 tdmd <= txon & (set_req | (tdmd & ~poll_ack));
    end
endmodule

// File: rtl/netctl_csr.sv
// Top of the command/interrupt register: decodes host writes into commands,
// wires the sequencer, interrupt aggregator and demand handshake, and
// assembles the read word. Reads are combinational and have no side effects.
module netctl_csr
    import netctl_pkg::*;
#(
    parameter int N_EXT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    output logic [CSR_W-1:0] rd_data,
    input  logic [CSR_W-1:0] int_mask,
    input  logic             cfg_tx_quiet,
    input  logic             cfg_rx_dis,
    input  logic             cfg_tx_dis,
    input  logic             ev_tx_done,
    input  logic             ev_tx_ok,
    input  logic             ev_init_done,
    input  logic [N_EXT-1:0] ext_cause,
    input  logic             sys_cause,
    output logic             init_busy,
    output logic             poll_req,
    input  logic             poll_ack,
    output logic             irq_n
);
    localparam int PAD_W = CSR_W - B_TXINT - 1;

    cmd_t cmd;
    logic stop, started, start_pend, rxon, txon, init_fin, flush;
    logic txint, idon, ien, summary, tdmd;

    // Command decode; stop overrides start and init in the same write.
    always_comb begin
        cmd.stop  = wr_en & wr_data[B_STOP];
        cmd.start = wr_en & wr_data[B_START] & ~wr_data[B_STOP];
        cmd.init  = wr_en & wr_data[B_INIT]  & ~wr_data[B_STOP];
    end

    netctl_cmd_seq u_seq (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cmd(cmd),
        .init_done_ev(ev_init_done), .cfg_rx_dis(cfg_rx_dis),
        .cfg_tx_dis(cfg_tx_dis), .stop(stop), .started(started),
        .start_pend(start_pend), .init_busy(init_busy), .rxon(rxon),
        .txon(txon), .init_fin(init_fin), .flush(flush)
    );

    netctl_int_agg #(.N_EXT(N_EXT)) u_agg (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en),
        .wr_data(wr_data), .ev_tx_done(ev_tx_done), .ev_tx_ok(ev_tx_ok),
        .cfg_tx_quiet(cfg_tx_quiet), .init_fin(init_fin), .stop(stop),
        .int_mask(int_mask), .ext_cause(ext_cause), .sys_cause(sys_cause),
        .txint(txint), .idon(idon), .ien(ien), .summary(summary),
        .irq_n(irq_n)
    );

    netctl_tx_demand u_dmd (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .set_req(wr_en & wr_data[B_TDMD]), .txon(txon),
        .poll_ack(poll_ack), .tdmd(tdmd)
    );

    // Read word assembly and the poll request.
    always_comb begin
        poll_req = tdmd;
        rd_data  = {{PAD_W{1'b0}}, txint, idon, summary, ien, rxon, txon,
                    tdmd, stop, started | start_pend, init_busy};
    end
endmodule

// File: rtl/netctl_csr_chk.sv
// Port-level protocol checks for netctl_csr, attached with bind.
module netctl_csr_chk
    import netctl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [CSR_W-1:0] wr_data,
    input logic [CSR_W-1:0] rd_data,
    input logic [CSR_W-1:0] int_mask,
    input logic             ev_tx_done,
    input logic             sys_cause,
    input logic             poll_req,
    input logic             irq_n
);
    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[B_STOP]) |=> (rd_data[B_STOP] && rd_data[9:8] == 2'b00
                                       && rd_data[6:3] == 4'b0000 && rd_data[1:0] == 2'b00)); // R10
    AST_RXON_NOT_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[B_RXON]) |-> !rd_data[B_STOP]); // R7
    AST_POLL_NEEDS_TXON: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req |-> rd_data[B_TXON]); // R9
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> $past(sys_cause || (rd_data[B_IEN] && rd_data[B_SUM]))); // R5
    AST_SUMMARY_TXINT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[B_TXINT] && !int_mask[B_TXINT]) |-> rd_data[B_SUM]); // R4
    AST_TXINT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && $past(wr_data[B_TXINT]) && !$past(ev_tx_done)) |-> !rd_data[B_TXINT]); // R3
endmodule

bind netctl_csr netctl_csr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .int_mask(int_mask), .ev_tx_done(ev_tx_done),
    .sys_cause(sys_cause), .poll_req(poll_req), .irq_n(irq_n)
);

// File: tb/sim_netctl_csr.sv
`timescale 1ns/1ps
module sim_netctl_csr;
    localparam int N_EXT = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, soft_rst, wr_en, cfg_tx_quiet, cfg_rx_dis, cfg_tx_dis;
    logic ev_tx_done, ev_tx_ok, ev_init_done, sys_cause, poll_ack;
    logic [15:0] wr_data, int_mask, rd_data;
    logic [N_EXT-1:0] ext_cause;
    logic init_busy, poll_req, irq_n;

    netctl_csr #(.N_EXT(N_EXT)) u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .int_mask(int_mask),
        .cfg_tx_quiet(cfg_tx_quiet), .cfg_rx_dis(cfg_rx_dis),
        .cfg_tx_dis(cfg_tx_dis), .ev_tx_done(ev_tx_done), .ev_tx_ok(ev_tx_ok),
        .ev_init_done(ev_init_done), .ext_cause(ext_cause),
        .sys_cause(sys_cause), .init_busy(init_busy), .poll_req(poll_req),
        .poll_ack(poll_ack), .irq_n(irq_n)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // Behavioural reference state
    bit m_txint, m_idon, m_ien, m_rxon, m_txon, m_tdmd, m_stop;
    bit m_busy, m_pend, m_started, m_irqn;

    function automatic bit m_sum();
        return (m_txint && !int_mask[9]) || (m_idon && !int_mask[8])
               || (ext_cause != '0) || sys_cause;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    task automatic compare();
        chk("R1 bits15:10", int'(rd_data[15:10]), 0);
        chk("R2/R3 txint", int'(rd_data[9]), int'(m_txint));
        chk("R3/R8 idon", int'(rd_data[8]), int'(m_idon));
        chk("R4 summary", int'(rd_data[7]), int'(m_sum()));
        chk("R6 enable", int'(rd_data[6]), int'(m_ien));
        chk("R7 rxon", int'(rd_data[5]), int'(m_rxon));
        chk("R7 txon", int'(rd_data[4]), int'(m_txon));
        chk("R9 tdmd", int'(rd_data[3]), int'(m_tdmd));
        chk("R10 stop", int'(rd_data[2]), int'(m_stop));
        chk("R7 start", int'(rd_data[1]), int'(m_started || m_pend));
        chk("R8 busy bit", int'(rd_data[0]), int'(m_busy));
        chk("R8 init_busy", int'(init_busy), int'(m_busy));
        chk("R9 poll_req", int'(poll_req), int'(m_tdmd));
        chk("R5 irq_n", int'(irq_n), int'(m_irqn));
    endtask

    task automatic model_step();
        bit sum, c_stop, c_start, c_init, fin, pset, go, o_txon;
        sum     = m_sum();
        o_txon  = m_txon;
        c_stop  = wr_en && wr_data[2];
        c_start = wr_en && wr_data[1] && !wr_data[2];
        c_init  = wr_en && wr_data[0] && !wr_data[2];
        if (!rst_n) begin
            {m_txint, m_idon, m_ien, m_rxon, m_txon, m_tdmd} = '0;
            {m_busy, m_pend, m_started} = '0;
            m_stop = 1; m_irqn = 1;
            return;
        end
        m_irqn = !((m_ien && sum) || sys_cause);
        if (soft_rst || c_stop) begin
            {m_txint, m_idon, m_ien, m_rxon, m_txon, m_tdmd} = '0;
            {m_busy, m_pend, m_started} = '0;
            m_stop = 1;
            return;
        end
        fin  = m_busy && ev_init_done && !c_init;
        pset = c_start && (c_init || (m_busy && !ev_init_done));
        go   = (c_start && !pset) || (fin && m_pend);
        m_txint = (ev_tx_done && !m_stop && !(cfg_tx_quiet && ev_tx_ok))
                  || (m_txint && !(wr_en && wr_data[9]));
        m_idon  = fin || (m_idon && !(wr_en && wr_data[8]));
        if (wr_en) m_ien = wr_data[6];
        m_tdmd = o_txon && ((wr_en && wr_data[3]) || (m_tdmd && !poll_ack));
        if (c_start || c_init) m_stop = 0;
        if (c_init) m_busy = 1; else if (fin) m_busy = 0;
        if (pset) m_pend = 1; else if (fin) m_pend = 0;
        if (go) begin m_started = 1; m_rxon = !cfg_rx_dis; m_txon = !cfg_tx_dis; end
    endtask

    // One cycle: compare after inputs settle, then advance the model at the edge.
    task automatic tick();
        #0.5 compare();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en = 1; wr_data = d; tick(); wr_en = 0; wr_data = '0;
    endtask

    task automatic pulse_tx(input bit ok);
        ev_tx_done = 1; ev_tx_ok = ok; tick(); ev_tx_done = 0; ev_tx_ok = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; soft_rst = 0; wr_en = 0; wr_data = '0; int_mask = '0;
        cfg_tx_quiet = 0; cfg_rx_dis = 0; cfg_tx_dis = 0;
        ev_tx_done = 0; ev_tx_ok = 0; ev_init_done = 0;
        ext_cause = '0; sys_cause = 0; poll_ack = 0;
        @(posedge clk); model_step(); @(negedge clk);
        tick(); tick();
        rst_n = 1;
        #0.5 chk("R1 reset word", int'(rd_data), 16'h0004);   // R1
        tick();
        pulse_tx(0); tick();                          // R2: stopped, no set
        wr(16'h0040); tick();                         // R6 enable on
        cfg_tx_dis = 1; wr(16'h0042); tick();         // R7 rx only
        cfg_tx_dis = 0; wr(16'h0042); tick();         // R7 both on
        pulse_tx(0); tick(); tick();                  // R2 R4 R5
        int_mask[9] = 1; tick(); tick();              // R4 masked
        int_mask[9] = 0;
        wr(16'h0040); tick();                         // R3 write 0 keeps
        wr(16'h0240); tick();                         // R3 clear
        cfg_tx_quiet = 1; pulse_tx(1); tick();        // R2 suppressed
        pulse_tx(0); tick(); cfg_tx_quiet = 0;        // R2 error still sets
        ev_tx_done = 1; wr(16'h0240); ev_tx_done = 0; // R3 set wins
        tick(); wr(16'h0240); tick();
        wr(16'h0048); tick(); tick();                 // R9 demand
        poll_ack = 1; tick(); poll_ack = 0; tick();   // R9 ack
        wr(16'h0048);
        poll_ack = 1; wr(16'h0048); poll_ack = 0;     // R9 ack with new write
        tick(); poll_ack = 1; tick(); poll_ack = 0;
        wr(16'h0000); sys_cause = 1; tick(); tick();  // R5 bypass
        sys_cause = 0; tick();
        ext_cause = 4'b0100; wr(16'h0040); tick();    // R4 R5 external
        ext_cause = '0; tick();
        wr(16'h0047); tick();                         // R10 stop wins
        wr(16'h0008); tick();                         // R9 no txon
        wr(16'h0043); repeat (4) tick();              // R8 waiting
        ev_init_done = 1; tick(); ev_init_done = 0; tick(); tick();
        wr(16'h0041); tick();                         // R8 init while running
        wr(16'h0042); tick();                         // R8 start pends
        cfg_rx_dis = 1;
        ev_init_done = 1; tick(); ev_init_done = 0; tick();
        cfg_rx_dis = 0;
        soft_rst = 1; tick(); soft_rst = 0; tick();   // R10 soft reset
        wr(16'h0042); pulse_tx(0); wr(16'h0040); tick(); tick();
        rst_n = 0; tick(); tick(); rst_n = 1; tick(); // R1 released in reset
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule